// File: doc/BRIEF.md
# Interrupt Level Request Selector

This block sits between the external interrupt lines of a processor and its trap entry logic. It watches fifteen pending interrupt levels, numbered 1 to 15, and keeps a registered pending-trap index that the core reads. When at least one level is asserted and the slot is free or already holds an external-interrupt code, the block installs the code of the highest asserted level. That code is the external-interrupt base 0x10 combined with the 4-bit level, so the values run from 0x11 to 0x1F. At the same time the block raises a hard interrupt request to the core.

The request and index stay as they are while the selected level does not change. When every level has gone away and an interrupt code is still pending, the block clears both the index and the request. A pending trap of any other class is left alone until the core replaces it. The core loads or clears the index with a one-cycle write pulse. Each change of the index comes with a one-cycle strobe, which can drive tracing or acknowledgment logic. Masking against the processor interrupt level is done elsewhere.

Top module: `lvl_req_sel`

## Requirements
- R1: While rst_n is low at a rising clock edge, the registers are cleared, so trap_idx_o = 0, irq_req_o = 0 and chg_o = 0 after that edge.
- R2: Bit k-1 of lvl_i is interrupt level k. When the block installs an interrupt code, it picks the highest asserted level L, and the code is 0x10 | L.
- R3: A level code may be installed only when the current index is 0 or its upper four bits are 0001. A current index of 0x10 counts as the interrupt class.
- R4: irq_req_o is 1 exactly when trap_idx_o has upper bits 0001 and a nonzero low nibble. It rises when a level code is installed and stays high while that code is held.
- R5: chg_o is 1 in exactly those cycles where trap_idx_o differs from its value one cycle earlier. Selecting the same level again produces no strobe and no new request edge.
- R6: With lvl_i all zero and an interrupt-class index pending, the next edge sets the index to 0 and drops irq_req_o.
- R7: While the pending index is nonzero and outside the interrupt class, lvl_i has no effect, and the index and request hold until the core writes.
- R8: A cycle with core_wr_i = 1 loads core_idx_i into the index. This takes priority over level arbitration, and irq_req_o follows the R4 rule for the loaded value.
- R9: Every update takes effect on the rising clock edge after its inputs, so outputs do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_i | input | 15 | Pending interrupt levels; bit k-1 is level k |
| core_wr_i | input | 1 | One-cycle pulse from the core that loads core_idx_i |
| core_idx_i | input | 8 | Index value written by the core (0 clears) |
| trap_idx_o | output | 8 | Registered pending-trap index |
| irq_req_o | output | 1 | Hard interrupt request to the core |
| chg_o | output | 1 | One-cycle strobe marking an index change |

## Verification
The bench applies single levels, which test the mapping from a level to its code. It also applies dense random vectors and all levels together, which show whether the highest level truly wins over lower ones. Levels rising above, falling below and repeating the held level separate a real change from a repeated selection, which must produce no strobe. Core writes of 0, of interrupt-class codes such as 0x10 and 0x13, and of other-class codes such as 0x07 and 0x20 show whether arbitration respects a pending non-interrupt trap. They also check that a fall to all-zero levels clears only interrupt-class codes.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    localparam int LRS_LEVELS = 15;
    localparam int LRS_LVL_W  = $clog2(LRS_LEVELS + 1);
    localparam int LRS_IDX_W  = 8;

    typedef logic [LRS_IDX_W-1:0] trap_idx_t;

    typedef struct packed {
        trap_idx_t idx;
        logic      req;
        logic      chg;
    } lrs_state_t;
endpackage

// File: rtl/lvl_prio_enc.sv
module lvl_prio_enc #(
    parameter int N = 15,
    parameter int W = 4
) (
    input  logic [N-1:0] req_vec,
    output logic         any,
    output logic [W-1:0] top
);
    // masked[k] is set when level k+1 is asserted and no higher level is
    logic [N-1:0] above;
    logic [N-1:0] masked;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_lvl
            if (g == N - 1) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_mid
                assign above[g] = above[g+1] | req_vec[g+1];
            end
            assign masked[g] = req_vec[g] & ~above[g];
        end
    endgenerate

    always_comb begin
        top = '0;
        for (int k = 0; k < N; k++) begin
            if (masked[k]) top = top | W'(k + 1);
        end
        any = |req_vec;
    end
endmodule

// File: rtl/trap_class.sv
module trap_class #(
    parameter int                IDX_W    = 8,
    parameter int                LVL_W    = 4,
    parameter logic [IDX_W-1:0]  EXT_BASE = 8'h10
) (
    input  logic [IDX_W-1:0] idx,
    output logic             is_zero,
    output logic             is_ext,
    output logic             is_ext_lvl
);
    localparam int HI_W = IDX_W - LVL_W;

    logic [HI_W-1:0] hi_bits;
    logic [HI_W-1:0] base_hi;

    always_comb begin
        hi_bits    = idx[IDX_W-1:LVL_W];
        base_hi    = EXT_BASE[IDX_W-1:LVL_W];
        is_zero    = (idx == '0);
        is_ext     = (hi_bits == base_hi);
        is_ext_lvl = is_ext && (idx[LVL_W-1:0] != '0);
    end
endmodule

// File: rtl/trap_idx_arb.sv
module trap_idx_arb
    import lrs_pkg::*;
#(
    parameter int               IDX_W    = LRS_IDX_W,
    parameter int               LVL_W    = LRS_LVL_W,
    parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
    input  lrs_state_t       st_q,
    input  logic             lvl_any,
    input  logic [LVL_W-1:0] lvl_top,
    input  logic             cur_zero,
    input  logic             cur_ext,
    input  logic             core_wr,
    input  logic [IDX_W-1:0] core_idx,
    input  logic             core_ext_lvl,
    output lrs_state_t       st_d
);
    logic [IDX_W-1:0] cand;

    always_comb begin
        cand     = EXT_BASE | IDX_W'(lvl_top);
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (core_wr) begin
            // core write overrides arbitration
            st_d.idx = core_idx;
            st_d.req = core_ext_lvl;
            st_d.chg = (core_idx != st_q.idx);
        end else if (lvl_any && (cur_zero || cur_ext)) begin
            if (cand != st_q.idx) begin
                st_d.idx = cand;
                st_d.req = 1'b1;
                st_d.chg = 1'b1;
            end
        end else if (!lvl_any && cur_ext) begin
            st_d.idx = '0;
            st_d.req = 1'b0;
            st_d.chg = 1'b1;
        end
    end
endmodule

// File: rtl/lvl_req_sel.sv
module lvl_req_sel
    import lrs_pkg::*;
#(
    parameter logic [LRS_IDX_W-1:0] EXT_BASE = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LRS_LEVELS-1:0] lvl_i,
    input  logic                  core_wr_i,
    input  logic [LRS_IDX_W-1:0]  core_idx_i,
    output logic [LRS_IDX_W-1:0]  trap_idx_o,
    output logic                  irq_req_o,
    output logic                  chg_o
);
    lrs_state_t st_q;
    lrs_state_t st_d;

    logic                 lvl_any;
    logic [LRS_LVL_W-1:0] lvl_top;
    logic                 cur_zero;
    logic                 cur_ext;
    logic                 cur_ext_lvl;
    logic                 core_zero;
    logic                 core_ext;
    logic                 core_ext_lvl;

    lvl_prio_enc #(.N(LRS_LEVELS), .W(LRS_LVL_W)) u_enc (
        .req_vec (lvl_i),
        .any     (lvl_any),
        .top     (lvl_top)
    );

    trap_class #(.IDX_W(LRS_IDX_W), .LVL_W(LRS_LVL_W), .EXT_BASE(EXT_BASE)) u_cur_cls (
        .idx        (st_q.idx),
        .is_zero    (cur_zero),
        .is_ext     (cur_ext),
        .is_ext_lvl (cur_ext_lvl)
    );

    trap_class #(.IDX_W(LRS_IDX_W), .LVL_W(LRS_LVL_W), .EXT_BASE(EXT_BASE)) u_core_cls (
        .idx        (core_idx_i),
        .is_zero    (core_zero),
        .is_ext     (core_ext),
        .is_ext_lvl (core_ext_lvl)
    );

    trap_idx_arb #(.IDX_W(LRS_IDX_W), .LVL_W(LRS_LVL_W), .EXT_BASE(EXT_BASE)) u_arb (
        .st_q         (st_q),
        .lvl_any      (lvl_any),
        .lvl_top      (lvl_top),
        .cur_zero     (cur_zero),
        .cur_ext      (cur_ext),
        .core_wr      (core_wr_i),
        .core_idx     (core_idx_i),
        .core_ext_lvl (core_ext_lvl),
        .st_d         (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_idx_o = st_q.idx;
    assign irq_req_o  = st_q.req;
    assign chg_o      = st_q.chg;

    logic unused_cls;
    assign unused_cls = cur_ext_lvl ^ core_zero ^ core_ext;
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
    parameter int               LEVELS   = 15,
    parameter int               IDX_W    = 8,
    parameter int               LVL_W    = 4,
    parameter logic [IDX_W-1:0] EXT_BASE = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEVELS-1:0] lvl_i,
    input logic              core_wr_i,
    input logic [IDX_W-1:0]  core_idx_i,
    input logic [IDX_W-1:0]  trap_idx_o,
    input logic              irq_req_o,
    input logic              chg_o
);
    logic out_ext;
    assign out_ext = (trap_idx_o[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W]);

    // R4
    req_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o == (out_ext && trap_idx_o[LVL_W-1:0] != '0));

    // R5
    strobe_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> (trap_idx_o != $past(trap_idx_o)));

    // R5
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_o |-> $stable(trap_idx_o));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_wr_i && lvl_i == '0 && out_ext) |=> (trap_idx_o == '0 && !irq_req_o && chg_o));

    // R7
    hold_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_wr_i && trap_idx_o != '0 && !out_ext) |=> ($stable(trap_idx_o) && !chg_o));

    // R3
    install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_wr_i && lvl_i != '0 && (trap_idx_o == '0 || out_ext)) |=>
        (trap_idx_o[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W] && irq_req_o));

    // R8
    core_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_i |=> (trap_idx_o == $past(core_idx_i)));
endmodule

bind lvl_req_sel lrs_chk #(
    .LEVELS   (lrs_pkg::LRS_LEVELS),
    .IDX_W    (lrs_pkg::LRS_IDX_W),
    .LVL_W    (lrs_pkg::LRS_LVL_W),
    .EXT_BASE (EXT_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl_i),
    .core_wr_i  (core_wr_i),
    .core_idx_i (core_idx_i),
    .trap_idx_o (trap_idx_o),
    .irq_req_o  (irq_req_o),
    .chg_o      (chg_o)
);

// File: tb/lvl_req_sel_tb.sv
module lvl_req_sel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] lvl_i = '0;
    logic        core_wr_i = 1'b0;
    logic [7:0]  core_idx_i = '0;
    logic [7:0]  trap_idx_o;
    logic        irq_req_o;
    logic        chg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_idx = '0;
    logic       m_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_req_sel u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_i),
        .core_wr_i  (core_wr_i),
        .core_idx_i (core_idx_i),
        .trap_idx_o (trap_idx_o),
        .irq_req_o  (irq_req_o),
        .chg_o      (chg_o)
    );

    function automatic logic is_intr(input logic [7:0] v);
        return v[7:4] == 4'h1;
    endfunction

    function automatic logic [7:0] pick_code(input logic [14:0] lv);
        for (int k = 15; k >= 1; k--) begin
            if (lv[k-1]) return 8'h10 | 8'(k);
        end
        return 8'h00;
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply inputs at negedge, predict, sample after the edge
    task automatic step(input logic [14:0] lv, input logic wr, input logic [7:0] wv);
        logic [7:0] n_idx;
        logic       n_req;
        logic       n_chg;
        string      tag;
        @(negedge clk);
        lvl_i = lv; core_wr_i = wr; core_idx_i = wv;
        n_idx = m_idx; n_req = m_req; tag = "R5";
        if (wr) begin
            n_idx = wv; n_req = is_intr(wv) && wv[3:0] != 0; tag = "R8";
        end else if (lv != 0 && (m_idx == 0 || is_intr(m_idx))) begin
            n_idx = pick_code(lv); n_req = 1'b1; tag = "R2";
        end else if (lv == 0 && is_intr(m_idx)) begin
            n_idx = 8'h00; n_req = 1'b0; tag = "R6";
        end else if (m_idx != 0) begin
            tag = "R7";
        end
        n_chg = (n_idx != m_idx);
        @(posedge clk); #1;
        cmp(tag, trap_idx_o, n_idx);
        cmp("R4", {7'd0, irq_req_o}, {7'd0, n_req});
        cmp("R5", {7'd0, chg_o}, {7'd0, n_chg});
        m_idx = n_idx; m_req = n_req;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        if (!done) begin
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        cmp("R1", trap_idx_o, 8'h00);
        cmp("R1", {7'd0, irq_req_o}, 8'h00);
        cmp("R1", {7'd0, chg_o}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R2 single level 5, then all levels -> level 15 wins
        step(15'h0010, 1'b0, 8'h00);
        cmp("R2", trap_idx_o, 8'h15);
        step(15'h7FFF, 1'b0, 8'h00);
        cmp("R2", trap_idx_o, 8'h1F);
        // R5 same level again: no strobe
        step(15'h4001, 1'b0, 8'h00);
        cmp("R5", {7'd0, chg_o}, 8'h00);
        // R2 lower level after higher goes away
        step(15'h0001, 1'b0, 8'h00);
        cmp("R2", trap_idx_o, 8'h11);
        // R6 all clear
        step(15'h0000, 1'b0, 8'h00);
        cmp("R6", trap_idx_o, 8'h00);

        // R9 inputs applied, output unchanged before the edge
        @(negedge clk); lvl_i = 15'h0100;
        #1; cmp("R9", trap_idx_o, 8'h00);
        @(posedge clk); #1;
        cmp("R9", trap_idx_o, 8'h19);
        m_idx = 8'h19; m_req = 1'b1;

        // R7 / R8 non-interrupt trap pending: levels ignored
        step(15'h0100, 1'b1, 8'h07);
        cmp("R8", trap_idx_o, 8'h07);
        step(15'h7FFF, 1'b0, 8'h00);
        cmp("R7", trap_idx_o, 8'h07);
        step(15'h0000, 1'b0, 8'h00);
        cmp("R7", trap_idx_o, 8'h07);
        // R3 class 0x20 is not interrupt class
        step(15'h0000, 1'b1, 8'h20);
        step(15'h0002, 1'b0, 8'h00);
        cmp("R3", trap_idx_o, 8'h20);
        // R3 0x10 counts as interrupt class
        step(15'h0000, 1'b1, 8'h10);
        cmp("R4", {7'd0, irq_req_o}, 8'h00);
        step(15'h0004, 1'b0, 8'h00);
        cmp("R3", trap_idx_o, 8'h13);
        // R8 core clear
        step(15'h0004, 1'b1, 8'h00);
        cmp("R8", trap_idx_o, 8'h00);
        step(15'h0000, 1'b0, 8'h00);

        for (int i = 0; i < NRAND; i++) begin
            logic [14:0] lv;
            logic        wr;
            logic [7:0]  wv;
            int          r;
            r  = $urandom % 4;
            lv = (r == 0) ? 15'h0 : (r == 1) ? 15'(1 << ($urandom % 15)) : 15'($urandom);
            wr = ($urandom % 12) == 0;
            r  = $urandom % 4;
            wv = (r == 0) ? 8'h00 : (r == 1) ? 8'(8'h10 | ($urandom % 16)) :
                 (r == 2) ? 8'h07 : 8'($urandom);
            step(lv, wr, wv);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule